// File: doc/BRIEF.md
# Instruction Cache Control Block with Line-Walk Invalidation

This block is the software-visible control face of an instruction cache. It sits on a simple 32-bit register bus and holds the cache on/off bit and the associativity choice. It also runs the full-invalidate procedure. A single write launches a walk that emits one invalidate strobe per clock, with a line index, towards the tag array. A busy flag and a finished flag let software follow the walk.

The block keeps two event counters that are fed by hit and miss strobes from the lookup logic. Each counter has its own enable and its own hold-at-zero bit. An error strobe from the cache sets a sticky error flag. Software clears the finished and error flags by writing ones to a separate clear register. A single interrupt line is raised when any flag is set together with its enable bit.

The usual sequence is: clear the finished flag, launch the walk, then poll the finished flag or wait for the interrupt. The walk sequencer is a three-state machine:
- `SEQ_IDLE` goes to `SEQ_WALK` on a launch.
- `SEQ_WALK` steps the index and goes to `SEQ_DONE` after the last line.
- `SEQ_DONE` returns to `SEQ_IDLE` and sets the finished flag.

Top module: `icache_ctl`

## Requirements
- R1: After reset the control word reads 0x0000_0004 (cache off, set-associative), status, interrupt enable and both counters read 0, and `irq` is 0. Register byte offsets: control 0x00, status 0x04, interrupt enable 0x08, flag clear 0x0C, hit counter 0x10, miss counter 0x14. Unmapped offsets read 0.
- R2: Control bit 0 is the cache enable. It reads back as written and drives `cache_en`.
- R3: Control bit 2 selects the associativity: 1 is set-associative and 0 is direct mapped. It drives `way_assoc`. A write to this bit is ignored while the enable bit is already 1.
- R4: Writing 1 to control bit 1 while no walk runs starts a walk. From the next clock, `inv_line_valid` is high for exactly N consecutive cycles, and `inv_line_idx` goes 0, 1, …, N-1. N is 8192/16/2 = 256 in set-associative mode and 512 in direct-mapped mode, taken from the mode at launch. Status bit 0 (busy) reads 1 during the walk.
- R5: When the walk ends, busy drops and status bit 1 (finished) sets on the same clock. Control bit 1 reads as busy, so it clears by itself. A launch written while a walk runs is ignored and does not restart the walk.
- R6: Writing 1 to bit 1 or bit 2 of the flag clear register clears the finished or error flag respectively. Writing 0 has no effect. A set and a clear in the same cycle leave the flag set.
- R7: A one-cycle `err_strobe` sets status bit 2 (error) on the next clock.
- R8: `irq` is high exactly when (finished AND interrupt-enable bit 1) OR (error AND interrupt-enable bit 2).
- R9: The hit counter (32 bits) counts `hit_strobe` cycles only while control bit 16 is 1. The miss counter (16 bits) counts `miss_strobe` cycles only while control bit 17 is 1. Each counter saturates at all ones.
- R10: While control bit 18 (hit) or bit 19 (miss) is 1, the matching counter is held at 0. Counting resumes from 0 once the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| hit_strobe | input | 1 | One cache hit this cycle |
| miss_strobe | input | 1 | One cache miss this cycle |
| err_strobe | input | 1 | Cache error event |
| cache_en | output | 1 | Cache enable to the lookup logic |
| way_assoc | output | 1 | 1 = set-associative, 0 = direct mapped |
| inv_line_valid | output | 1 | Invalidate the line at `inv_line_idx` this cycle |
| inv_line_idx | output | log2(lines) | Line index being invalidated |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following:
- the invalidate index steps by one with no gaps, and strobes only while busy;
- the finished flag rises only as busy falls;
- an error strobe always lands in the error flag;
- the associativity bit stays fixed while the cache is on;
- a held counter reset keeps a counter at zero;
- a saturated counter stays at all ones;
- a disabled counter never moves upward;
- the interrupt never rises without a flag.

The bench scenarios are the only way to show the following:
- the exact walk lengths of 256 and 512;
- that a second launch during a walk does not restart it;
- write-one-to-clear against a write of zero;
- interrupt masking by each enable bit;
- the locked-then-accepted behaviour of the associativity bit across a disable.

// File: rtl/icc_pkg.sv
package icc_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WALK = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_t;

    localparam logic [7:0] OFS_CTL  = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_IE   = 8'h08;
    localparam logic [7:0] OFS_CLR  = 8'h0C;
    localparam logic [7:0] OFS_HIT  = 8'h10;
    localparam logic [7:0] OFS_MISS = 8'h14;

    localparam int B_EN   = 0;
    localparam int B_INV  = 1;
    localparam int B_WAY  = 2;
    localparam int B_HEN  = 16;
    localparam int B_MEN  = 17;
    localparam int B_HRST = 18;
    localparam int B_MRST = 19;

    localparam int F_BUSY = 0;
    localparam int F_FIN  = 1;
    localparam int F_ERR  = 2;
endpackage

// File: rtl/icc_inv_seq.sv
module icc_inv_seq
    import icc_pkg::*;
#(
    parameter int LINES      = 512,
    parameter int ASSOC_WAYS = 2,
    localparam int IDX_W     = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             assoc_mode,
    output logic             busy,
    output logic             done,
    output logic             line_valid,
    output logic [IDX_W-1:0] line_idx
);
    localparam logic [IDX_W-1:0] LAST_DM = IDX_W'(LINES - 1);
    localparam logic [IDX_W-1:0] LAST_SA = IDX_W'(LINES / ASSOC_WAYS - 1);

    seq_state_t       st_q, st_d;
    logic [IDX_W-1:0] idx_q, last_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE: if (start) st_d = SEQ_WALK;
            SEQ_WALK: if (idx_q == last_q) st_d = SEQ_DONE;
            SEQ_DONE: st_d = SEQ_IDLE;
            default:  st_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            last_q <= LAST_SA;
        end else if (st_q == SEQ_IDLE && start) begin
            idx_q  <= '0;
            last_q <= assoc_mode ? LAST_SA : LAST_DM;
        end else if (st_q == SEQ_WALK) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy       = (st_q != SEQ_IDLE);
        line_valid = (st_q == SEQ_WALK);
        done       = (st_q == SEQ_DONE);
        line_idx   = idx_q;
    end
endmodule

// File: rtl/icc_monitor.sv
module icc_monitor #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         hold_zero,
    input  logic         evt,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          count <= '0;
        else if (hold_zero)                  count <= '0;
        else if (en && evt && count != TOP)  count <= count + 1'b1;
    end
endmodule

// File: rtl/icache_ctl.sv
module icache_ctl
    import icc_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int CACHE_BYTES = 8192,
    parameter int LINE_BYTES  = 16,
    parameter int ASSOC_WAYS  = 2,
    parameter int HIT_W       = 32,
    parameter int MISS_W      = 16,
    localparam int LINES      = CACHE_BYTES / LINE_BYTES,
    localparam int IDX_W      = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              hit_strobe,
    input  logic              miss_strobe,
    input  logic              err_strobe,
    output logic              cache_en,
    output logic              way_assoc,
    output logic              inv_line_valid,
    output logic [IDX_W-1:0]  inv_line_idx,
    output logic              irq
);
    logic en_q, way_q, hen_q, men_q, hrst_q, mrst_q;
    logic ie_fin_q, ie_err_q, fin_q, err_q;
    logic seq_busy, seq_done;
    logic [HIT_W-1:0]  hit_cnt;
    logic [MISS_W-1:0] miss_cnt;

    logic wr_ctl, wr_ie, wr_clr, launch;
    assign wr_ctl = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CTL));
    assign wr_ie  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_IE));
    assign wr_clr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CLR));
    assign launch = wr_ctl && bus_wdata[B_INV] && !seq_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; way_q <= 1'b1;
            hen_q <= 1'b0; men_q <= 1'b0; hrst_q <= 1'b0; mrst_q <= 1'b0;
        end else if (wr_ctl) begin
            en_q   <= bus_wdata[B_EN];
            if (!en_q) way_q <= bus_wdata[B_WAY];
            hen_q  <= bus_wdata[B_HEN];
            men_q  <= bus_wdata[B_MEN];
            hrst_q <= bus_wdata[B_HRST];
            mrst_q <= bus_wdata[B_MRST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_fin_q <= 1'b0; ie_err_q <= 1'b0;
        end else if (wr_ie) begin
            ie_fin_q <= bus_wdata[F_FIN];
            ie_err_q <= bus_wdata[F_ERR];
        end
    end

    // sticky flags: set wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fin_q <= 1'b0; err_q <= 1'b0;
        end else begin
            if (seq_done)                        fin_q <= 1'b1;
            else if (wr_clr && bus_wdata[F_FIN]) fin_q <= 1'b0;
            if (err_strobe)                      err_q <= 1'b1;
            else if (wr_clr && bus_wdata[F_ERR]) err_q <= 1'b0;
        end
    end

    icc_inv_seq #(.LINES(LINES), .ASSOC_WAYS(ASSOC_WAYS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(launch), .assoc_mode(way_q),
        .busy(seq_busy), .done(seq_done),
        .line_valid(inv_line_valid), .line_idx(inv_line_idx)
    );

    icc_monitor #(.W(HIT_W)) u_hit (
        .clk(clk), .rst_n(rst_n), .en(hen_q), .hold_zero(hrst_q),
        .evt(hit_strobe), .count(hit_cnt)
    );

    icc_monitor #(.W(MISS_W)) u_miss (
        .clk(clk), .rst_n(rst_n), .en(men_q), .hold_zero(mrst_q),
        .evt(miss_strobe), .count(miss_cnt)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTL): begin
                bus_rdata[B_EN]   = en_q;
                bus_rdata[B_INV]  = seq_busy;
                bus_rdata[B_WAY]  = way_q;
                bus_rdata[B_HEN]  = hen_q;
                bus_rdata[B_MEN]  = men_q;
                bus_rdata[B_HRST] = hrst_q;
                bus_rdata[B_MRST] = mrst_q;
            end
            ADDR_W'(OFS_STAT): begin
                bus_rdata[F_BUSY] = seq_busy;
                bus_rdata[F_FIN]  = fin_q;
                bus_rdata[F_ERR]  = err_q;
            end
            ADDR_W'(OFS_IE): begin
                bus_rdata[F_FIN] = ie_fin_q;
                bus_rdata[F_ERR] = ie_err_q;
            end
            ADDR_W'(OFS_HIT):  bus_rdata = 32'(hit_cnt);
            ADDR_W'(OFS_MISS): bus_rdata = 32'(miss_cnt);
            default:           bus_rdata = '0;
        endcase
    end

    assign cache_en  = en_q;
    assign way_assoc = way_q;
    assign irq       = (fin_q && ie_fin_q) || (err_q && ie_err_q);
endmodule

// File: rtl/icache_ctl_chk.sv
module icache_ctl_chk #(
    parameter int IDX_W  = 9,
    parameter int HIT_W  = 32,
    parameter int MISS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             fin,
    input logic             err,
    input logic             err_strobe,
    input logic             irq,
    input logic             line_valid,
    input logic [IDX_W-1:0] line_idx,
    input logic             en,
    input logic             way,
    input logic             hen,
    input logic             men,
    input logic             hrst,
    input logic             mrst,
    input logic [HIT_W-1:0]  hit_cnt,
    input logic [MISS_W-1:0] miss_cnt
);
    localparam logic [HIT_W-1:0]  HTOP = '1;
    localparam logic [MISS_W-1:0] MTOP = '1;

    a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && line_idx != '0) |-> ($past(line_valid) && line_idx == $past(line_idx) + 1'b1));
    a_r4_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> busy);
    a_r5_fin_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fin) |-> $fell(busy));
    a_r7_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe |=> err);
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (fin || err));
    a_r3_way_locked: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(way));
    a_r9_hit_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cnt == HTOP && !hrst) |=> hit_cnt == HTOP);
    a_r9_miss_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_cnt == MTOP && !mrst) |=> miss_cnt == MTOP);
    a_r9_hit_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !hen |=> ($stable(hit_cnt) || hit_cnt == '0));
    a_r9_miss_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !men |=> ($stable(miss_cnt) || miss_cnt == '0));
    a_r10_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hrst |=> hit_cnt == '0);
    a_r10_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> miss_cnt == '0);
endmodule

bind icache_ctl icache_ctl_chk #(.IDX_W(IDX_W), .HIT_W(HIT_W), .MISS_W(MISS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(seq_busy), .fin(fin_q), .err(err_q),
    .err_strobe(err_strobe), .irq(irq), .line_valid(inv_line_valid),
    .line_idx(inv_line_idx), .en(en_q), .way(way_q), .hen(hen_q), .men(men_q),
    .hrst(hrst_q), .mrst(mrst_q), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
);

// File: tb/icache_ctl_test.sv
`timescale 1ns/1ps
module icache_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hit_strobe = 1'b0, miss_strobe = 1'b0, err_strobe = 1'b0;
    logic        cache_en, way_assoc, inv_line_valid, irq;
    logic [8:0]  inv_line_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    icache_ctl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hit_strobe(hit_strobe), .miss_strobe(miss_strobe), .err_strobe(err_strobe),
        .cache_en(cache_en), .way_assoc(way_assoc), .inv_line_valid(inv_line_valid),
        .inv_line_idx(inv_line_idx), .irq(irq)
    );

    localparam logic [7:0] A_CTL = 8'h00, A_STAT = 8'h04, A_IE = 8'h08,
                           A_CLR = 8'h0C, A_HIT = 8'h10, A_MISS = 8'h14;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic pulse_hit(input int n);
        @(negedge clk); hit_strobe = 1'b1;
        repeat (n) @(negedge clk);
        hit_strobe = 1'b0;
    endtask

    task automatic pulse_miss(input int n);
        @(negedge clk); miss_strobe = 1'b1;
        repeat (n) @(negedge clk);
        miss_strobe = 1'b0;
    endtask

    // R1: reset values
    task automatic t_reset();
        logic [31:0] d;
        rd(A_CTL, d);  check("R1 ctl", d, 32'h4);
        rd(A_STAT, d); check("R1 stat", d, 32'h0);
        rd(A_IE, d);   check("R1 ie", d, 32'h0);
        rd(A_HIT, d);  check("R1 hit", d, 32'h0);
        rd(A_MISS, d); check("R1 miss", d, 32'h0);
        rd(8'h18, d);  check("R1 unmapped", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    // R2, R3: enable and way lock
    task automatic t_ctl();
        logic [31:0] d;
        wr(A_CTL, 32'h5); rd(A_CTL, d);
        check("R2 ctl en", d, 32'h5);
        check("R2 cache_en", {31'b0, cache_en}, 32'h1);
        wr(A_CTL, 32'h1); rd(A_CTL, d);
        check("R3 way ignored while on", d, 32'h5);
        check("R3 way_assoc held", {31'b0, way_assoc}, 32'h1);
        wr(A_CTL, 32'h4); rd(A_CTL, d);
        check("R2 disable", d, 32'h4);
        wr(A_CTL, 32'h0); rd(A_CTL, d);
        check("R3 way written when off", d, 32'h0);
        check("R3 way_assoc direct", {31'b0, way_assoc}, 32'h0);
    endtask

    // R4, R5: full walk; optionally a second launch mid-walk
    task automatic t_walk(input logic [31:0] ctl, input int n_exp, input bit inject);
        logic [31:0] d;
        int cnt = 0, bad = 0, guard = 0;
        wr(A_CTL, ctl | 32'h2);
        bus_addr = A_STAT; #1;
        check("R4 busy during walk", bus_rdata & 32'h1, 32'h1);
        while (inv_line_valid && guard < 2000) begin
            if (inv_line_idx !== cnt[8:0]) bad++;
            cnt++; guard++;
            if (inject && cnt == 10) begin
                bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CTL; bus_wdata = ctl | 32'h2;
            end else begin
                bus_sel = 1'b0; bus_wr = 1'b0;
            end
            @(negedge clk); #1;
        end
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R4 walk length", cnt, n_exp);
        check("R4 index sequence errors", bad, 0);
        rd(A_STAT, d); check("R5 busy low, finished set", d, 32'h2);
        rd(A_CTL, d);  check("R5 launch bit self-clears", d & 32'h2, 32'h0);
        check("R5 no restart", {31'b0, inv_line_valid}, 32'h0);
    endtask

    // R6: write-one-to-clear of finished
    task automatic t_clear_fin();
        logic [31:0] d;
        wr(A_CLR, 32'h0); rd(A_STAT, d);
        check("R6 zero write keeps flag", d, 32'h2);
        wr(A_CLR, 32'h2); rd(A_STAT, d);
        check("R6 clear finished", d, 32'h0);
    endtask

    // R7, R8, R6: error flag and irq masking
    task automatic t_irq();
        logic [31:0] d;
        wr(A_IE, 32'h2); #1;
        check("R8 irq on finished", {31'b0, irq}, 32'h1);
        wr(A_CLR, 32'h2); #1;
        check("R8 irq off after clear", {31'b0, irq}, 32'h0);
        @(negedge clk); err_strobe = 1'b1;
        @(negedge clk); err_strobe = 1'b0;
        rd(A_STAT, d); check("R7 error flag", d, 32'h4);
        check("R8 error masked", {31'b0, irq}, 32'h0);
        wr(A_IE, 32'h4); #1;
        check("R8 irq on error", {31'b0, irq}, 32'h1);
        wr(A_CLR, 32'h4); rd(A_STAT, d);
        check("R6 clear error", d, 32'h0);
        check("R8 irq off", {31'b0, irq}, 32'h0);
    endtask

    // R9, R10: hit counter gating and hold
    task automatic t_hit();
        logic [31:0] d;
        wr(A_CTL, 32'h4 | (32'h1 << 16));
        fork pulse_hit(5); pulse_miss(5); join
        rd(A_HIT, d);  check("R9 hit count", d, 32'd5);
        rd(A_MISS, d); check("R9 miss disabled", d, 32'd0);
        wr(A_CTL, 32'h4);
        pulse_hit(3);
        rd(A_HIT, d);  check("R9 hit disabled", d, 32'd5);
        wr(A_CTL, 32'h4 | (32'h1 << 16) | (32'h1 << 18));
        rd(A_HIT, d);  check("R10 hit zeroed", d, 32'd0);
        pulse_hit(4);
        rd(A_HIT, d);  check("R10 hit held", d, 32'd0);
        wr(A_CTL, 32'h4 | (32'h1 << 16));
        pulse_hit(2);
        rd(A_HIT, d);  check("R10 hit resumes", d, 32'd2);
    endtask

    // R9, R10: miss counter saturation and hold
    task automatic t_miss_sat();
        logic [31:0] d;
        wr(A_CTL, 32'h4 | (32'h1 << 17));
        pulse_miss(65540);
        rd(A_MISS, d); check("R9 miss saturates", d, 32'hFFFF);
        wr(A_CTL, 32'h4 | (32'h1 << 17) | (32'h1 << 19));
        rd(A_MISS, d); check("R10 miss zeroed", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctl();
        t_walk(32'h0, 512, 1'b1);
        t_clear_fin();
        wr(A_CTL, 32'h4);
        t_walk(32'h4, 256, 1'b0);
        t_irq();
        t_hit();
        t_miss_sat();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule